// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block steers the pipeline registers of a five-stage fetch, decode, execute, memory, writeback pipeline. From the instruction class codes held in decode, execute and memory, the two source register IDs in decode, the memory destination ID in execute and the execute condition flag, it raises three hazard conditions. These are a load followed closely by a use of the loaded value, a return in flight, and a conditional jump whose prediction turned out wrong. Those conditions feed a per-stage action table. The table produces a stall and a bubble mode bit for every stage register.

Only one action is applied per cycle, so when conditions overlap, the table resolves them explicitly. When a jump mispredicts while a return is in flight, the fetch register is held and the two younger stages are squashed. When a load/use hazard coincides with a return, the load/use action takes precedence: decode is held rather than squashed.

The same block contains the generic stage register driven by these modes. One instance each carries an opaque payload word for the fetch, decode and execute stages. Each instance raises an error flag if it is ever told to stall and bubble at the same time.

Top module: `hz_ctrl`

## Requirements
- R1: Class codes are 4 bits: nop=0, alu=1, load=2, pop=3, jump=4, ret=5, store=6, other=7. A load/use hazard exists when the execute class is load (2) or pop (3) and `e_dst_mem` equals `d_src_a` or `d_src_b`. It gives f_stall=1, d_stall=1, d_bubble=0, e_bubble=1 in the same cycle. No other execute class triggers it.
- R2: With a ret (5) in decode, execute or memory, and no load/use hazard present, the outputs are f_stall=1, d_bubble=1, d_stall=0, e_bubble=0.
- R3: A jump (4) in execute with `e_cond`=0 gives d_bubble=1 and e_bubble=1, with fetch in normal mode. A jump with `e_cond`=1 gives no action.
- R4: When a mispredicted jump and a ret in decode occur together, the outputs are f_stall=1, d_bubble=1, e_bubble=1, d_stall=0.
- R5: When a load/use hazard and a ret occur together, the load/use action applies unchanged and d_bubble stays 0.
- R6: The register ID with all bits set (0xF at the default width) means "no operand" and never produces a load/use match, even when both IDs carry it.
- R7: m_stall, m_bubble, w_stall, w_bubble, f_bubble and e_stall are always 0.
- R8: No stage register ever receives stall and bubble together, so `mode_err` stays 0.
- R9: A stage register in normal mode loads its input at the rising clock edge.
- R10: A stage register in stall mode keeps its output.
- R11: A stage register in bubble mode, or under reset, outputs the nop word (default 0x0010).
- R12: With no hazard condition present, every mode bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_class | input | 4 | Class code of the instruction in decode |
| e_class | input | 4 | Class code of the instruction in execute |
| m_class | input | 4 | Class code of the instruction in memory |
| d_src_a | input | RW | First decode source register ID |
| d_src_b | input | RW | Second decode source register ID |
| e_dst_mem | input | RW | Execute-stage memory destination register ID |
| e_cond | input | 1 | Execute-stage condition flag |
| f_next | input | PW | Payload offered to the fetch register |
| d_next | input | PW | Payload offered to the decode register |
| e_next | input | PW | Payload offered to the execute register |
| f_stall | output | 1 | Fetch register stall |
| f_bubble | output | 1 | Fetch register bubble |
| d_stall | output | 1 | Decode register stall |
| d_bubble | output | 1 | Decode register bubble |
| e_stall | output | 1 | Execute register stall |
| e_bubble | output | 1 | Execute register bubble |
| m_stall | output | 1 | Memory register stall |
| m_bubble | output | 1 | Memory register bubble |
| w_stall | output | 1 | Writeback register stall |
| w_bubble | output | 1 | Writeback register bubble |
| f_q | output | PW | Fetch register output |
| d_q | output | PW | Decode register output |
| e_q | output | PW | Execute register output |
| mode_err | output | 1 | Some stage register got stall and bubble together |

## Verification
A return can overlap with either of the other two conditions in one cycle. The bench provokes this in two ways. It places a ret in decode while execute holds a jump with a false flag. It also places a ret in decode while execute holds a load whose destination matches a decode source. The first overlap is judged by fetch holding while both decode and execute are squashed. The second is judged by decode holding its payload rather than taking the nop word, with `mode_err` staying low. Stage payloads are predicted by a separate register model in the bench and compared one cycle later.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
   localparam int CLASS_W = 4;

   typedef enum logic [CLASS_W-1:0] {
      CL_NOP   = 4'd0,
      CL_ALU   = 4'd1,
      CL_LOAD  = 4'd2,
      CL_POP   = 4'd3,
      CL_JUMP  = 4'd4,
      CL_RET   = 4'd5,
      CL_STORE = 4'd6,
      CL_OTHER = 4'd7
   } hz_class_e;

   typedef struct packed {
      logic stall;
      logic bubble;
   } hz_mode_s;

   localparam int N_STAGE = 5;
   localparam int ST_F = 0;
   localparam int ST_D = 1;
   localparam int ST_E = 2;
   localparam int ST_M = 3;
   localparam int ST_W = 4;
endpackage

// File: rtl/hz_detect.sv
`timescale 1ns/1ps
module hz_detect #(
   parameter int RW = 4
) (
   input  logic [hz_pkg::CLASS_W-1:0] d_class,
   input  logic [hz_pkg::CLASS_W-1:0] e_class,
   input  logic [hz_pkg::CLASS_W-1:0] m_class,
   input  logic [RW-1:0]              src_a,
   input  logic [RW-1:0]              src_b,
   input  logic [RW-1:0]              e_dst,
   input  logic                       e_cond,
   output logic                       lu_hit,
   output logic                       ret_hit,
   output logic                       mis_hit
);
   import hz_pkg::*;

   localparam logic [RW-1:0] NO_REG = {RW{1'b1}};
   localparam int N_SRC = 2;

   logic [RW-1:0]    src [N_SRC];
   logic [N_SRC-1:0] match;
   logic             e_is_load;

   assign src[0] = src_a;
   assign src[1] = src_b;

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         assign match[i] = (src[i] != NO_REG) && (src[i] == e_dst);
      end
   endgenerate

   assign e_is_load = (e_class == CL_LOAD) || (e_class == CL_POP);
   assign lu_hit    = e_is_load && (|match);
   assign ret_hit   = (d_class == CL_RET) || (e_class == CL_RET) || (m_class == CL_RET);
   assign mis_hit   = (e_class == CL_JUMP) && !e_cond;
endmodule

// File: rtl/hz_action.sv
`timescale 1ns/1ps
module hz_action (
   input  logic             lu_hit,
   input  logic             ret_hit,
   input  logic             mis_hit,
   output hz_pkg::hz_mode_s mode [hz_pkg::N_STAGE]
);
   import hz_pkg::*;

   localparam hz_mode_s NRM = '{stall: 1'b0, bubble: 1'b0};
   localparam hz_mode_s STL = '{stall: 1'b1, bubble: 1'b0};
   localparam hz_mode_s BUB = '{stall: 1'b0, bubble: 1'b1};

   always_comb begin
      for (int s = 0; s < N_STAGE; s++) mode[s] = NRM;
      case ({lu_hit, ret_hit, mis_hit})
         3'b001: begin mode[ST_D] = BUB; mode[ST_E] = BUB; end
         3'b010: begin mode[ST_F] = STL; mode[ST_D] = BUB; end
         3'b011: begin mode[ST_F] = STL; mode[ST_D] = BUB; mode[ST_E] = BUB; end
         3'b100,
         3'b101,
         3'b110,
         3'b111: begin mode[ST_F] = STL; mode[ST_D] = STL; mode[ST_E] = BUB; end
         default: ;
      endcase
   end
endmodule

// File: rtl/hz_pipe_reg.sv
`timescale 1ns/1ps
module hz_pipe_reg #(
   parameter int           W   = 16,
   parameter logic [W-1:0] NOP = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stall,
   input  logic         bubble,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         clash
);
   generate
      if (W < 1) begin : g_bad_w
         $error("hz_pipe_reg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= NOP;
      else if (bubble && !stall) q <= NOP;
      else if (!stall)           q <= d;
   end

   assign clash = stall && bubble;

   AST_NORMAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !bubble) |=> (q == $past(d)));                 // R9
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !bubble) |=> $stable(q));                       // R10
   AST_BUBBLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (bubble && !stall) |=> (q == NOP));                       // R11
endmodule

// File: rtl/hz_ctrl.sv
`timescale 1ns/1ps
module hz_ctrl #(
   parameter int            RW       = 4,
   parameter int            PW       = 16,
   parameter logic [PW-1:0] NOP_WORD = 16'h0010
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [hz_pkg::CLASS_W-1:0] d_class,
   input  logic [hz_pkg::CLASS_W-1:0] e_class,
   input  logic [hz_pkg::CLASS_W-1:0] m_class,
   input  logic [RW-1:0]              d_src_a,
   input  logic [RW-1:0]              d_src_b,
   input  logic [RW-1:0]              e_dst_mem,
   input  logic                       e_cond,
   input  logic [PW-1:0]              f_next,
   input  logic [PW-1:0]              d_next,
   input  logic [PW-1:0]              e_next,
   output logic                       f_stall,
   output logic                       f_bubble,
   output logic                       d_stall,
   output logic                       d_bubble,
   output logic                       e_stall,
   output logic                       e_bubble,
   output logic                       m_stall,
   output logic                       m_bubble,
   output logic                       w_stall,
   output logic                       w_bubble,
   output logic [PW-1:0]              f_q,
   output logic [PW-1:0]              d_q,
   output logic [PW-1:0]              e_q,
   output logic                       mode_err
);
   import hz_pkg::*;

   localparam int N_REG = 3;

   generate
      if (RW < 2) begin : g_bad_rw
         $error("hz_ctrl: RW must be at least 2");
      end
      if (PW < 1) begin : g_bad_pw
         $error("hz_ctrl: PW must be at least 1");
      end
   endgenerate

   logic             lu_hit, ret_hit, mis_hit;
   hz_mode_s         mode [N_STAGE];
   logic [PW-1:0]    nxt  [N_REG];
   logic [PW-1:0]    qv   [N_REG];
   logic [N_REG-1:0] clash;

   hz_detect #(.RW(RW)) i_detect (
      .d_class (d_class),
      .e_class (e_class),
      .m_class (m_class),
      .src_a   (d_src_a),
      .src_b   (d_src_b),
      .e_dst   (e_dst_mem),
      .e_cond  (e_cond),
      .lu_hit  (lu_hit),
      .ret_hit (ret_hit),
      .mis_hit (mis_hit)
   );

   hz_action i_action (
      .lu_hit  (lu_hit),
      .ret_hit (ret_hit),
      .mis_hit (mis_hit),
      .mode    (mode)
   );

   assign nxt[ST_F] = f_next;
   assign nxt[ST_D] = d_next;
   assign nxt[ST_E] = e_next;

   generate
      for (genvar s = 0; s < N_REG; s++) begin : g_stage
         hz_pipe_reg #(.W(PW), .NOP(NOP_WORD)) i_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .stall  (mode[s].stall),
            .bubble (mode[s].bubble),
            .d      (nxt[s]),
            .q      (qv[s]),
            .clash  (clash[s])
         );
      end
   endgenerate

   assign f_q      = qv[ST_F];
   assign d_q      = qv[ST_D];
   assign e_q      = qv[ST_E];
   assign mode_err = |clash;

   assign f_stall  = mode[ST_F].stall;
   assign f_bubble = mode[ST_F].bubble;
   assign d_stall  = mode[ST_D].stall;
   assign d_bubble = mode[ST_D].bubble;
   assign e_stall  = mode[ST_E].stall;
   assign e_bubble = mode[ST_E].bubble;
   assign m_stall  = mode[ST_M].stall;
   assign m_bubble = mode[ST_M].bubble;
   assign w_stall  = mode[ST_W].stall;
   assign w_bubble = mode[ST_W].bubble;

   AST_LU_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      lu_hit |-> (f_stall && d_stall && !d_bubble && e_bubble));           // R5
   AST_RET_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_hit && !lu_hit) |-> (f_stall && d_bubble && !d_stall));        // R2
   AST_MISPREDICT: assert property (@(posedge clk) disable iff (!rst_n)
      mis_hit |-> (d_bubble && e_bubble && !d_stall));                     // R3
   AST_NO_REG_ID: assert property (@(posedge clk) disable iff (!rst_n)
      (e_dst_mem == {RW{1'b1}}) |-> !lu_hit);                              // R6
   AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_err);                                                          // R8
endmodule

// File: tb/test_hz_ctrl.sv
`timescale 1ns/1ps
module test_hz_ctrl;
   import hz_pkg::*;

   localparam logic [15:0] NOPW = 16'h0010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  d_class = CL_NOP, e_class = CL_NOP, m_class = CL_NOP;
   logic [3:0]  d_src_a = 4'hF, d_src_b = 4'hF, e_dst_mem = 4'hF;
   logic        e_cond = 1'b0;
   logic [15:0] f_next = NOPW, d_next = NOPW, e_next = NOPW;
   logic        f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble;
   logic        m_stall, m_bubble, w_stall, w_bubble, mode_err;
   logic [15:0] f_q, d_q, e_q;

   always #5 clk = ~clk;

   hz_ctrl i_hz_ctrl (
      .clk(clk), .rst_n(rst_n),
      .d_class(d_class), .e_class(e_class), .m_class(m_class),
      .d_src_a(d_src_a), .d_src_b(d_src_b), .e_dst_mem(e_dst_mem), .e_cond(e_cond),
      .f_next(f_next), .d_next(d_next), .e_next(e_next),
      .f_stall(f_stall), .f_bubble(f_bubble), .d_stall(d_stall), .d_bubble(d_bubble),
      .e_stall(e_stall), .e_bubble(e_bubble), .m_stall(m_stall), .m_bubble(m_bubble),
      .w_stall(w_stall), .w_bubble(w_bubble),
      .f_q(f_q), .d_q(d_q), .e_q(e_q), .mode_err(mode_err)
   );

   typedef struct {
      string       tag;
      logic [9:0]  ctrl;
      logic [15:0] fq, dq, eq;
   } item_t;

   item_t       sb[$];
   int          n_chk = 0;
   int          n_err = 0;
   bit          done  = 1'b0;
   logic [15:0] m_f = NOPW, m_d = NOPW, m_e = NOPW;

   task automatic check16(string what, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // Driver: apply one cycle of inputs, push the expected result, advance the model.
   task automatic step(string tag, logic [3:0] dc, logic [3:0] ec, logic [3:0] mc,
                       logic [3:0] sa, logic [3:0] sbv, logic [3:0] ed, logic cond,
                       logic [3:0] exp_fdde);
      item_t it;
      logic fs, ds, db, eb;
      {fs, ds, db, eb} = exp_fdde;
      @(posedge clk); #1;
      d_class = dc; e_class = ec; m_class = mc;
      d_src_a = sa; d_src_b = sbv; e_dst_mem = ed; e_cond = cond;
      f_next = f_next + 16'h0101; d_next = d_next + 16'h0202; e_next = e_next + 16'h0303;
      it.tag  = tag;
      // R7: F bubble, E stall and all M/W bits expected 0
      it.ctrl = {fs, 1'b0, ds, db, 1'b0, eb, 4'b0000};
      it.fq = m_f; it.dq = m_d; it.eq = m_e;
      sb.push_back(it);
      // Register model: R9 load, R10 hold, R11 nop word
      if (!fs) m_f = f_next;
      if (db) m_d = NOPW; else if (!ds) m_d = d_next;
      if (eb) m_e = NOPW; else m_e = e_next;
   endtask

   // Monitor: compare at the falling edge of the cycle the item was applied.
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            item_t it;
            logic [9:0] act;
            it  = sb.pop_front();
            act = {f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble,
                   m_stall, m_bubble, w_stall, w_bubble};
            n_chk++;
            if (act !== it.ctrl) begin
               n_err++;
               $display("FAIL %s R7 modes actual=%b expected=%b", it.tag, act, it.ctrl);
            end
            n_chk++;
            if (mode_err !== 1'b0) begin
               n_err++;
               $display("FAIL %s R8 mode_err actual=%b expected=0", it.tag, mode_err);
            end
            check16({it.tag, " f_q R9 R10"}, f_q, it.fq);
            check16({it.tag, " d_q R9 R10 R11"}, d_q, it.dq);
            check16({it.tag, " e_q R9 R11"}, e_q, it.eq);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state of every stage register is the nop word
      check16("reset f_q R11", f_q, NOPW);
      check16("reset d_q R11", d_q, NOPW);
      check16("reset e_q R11", e_q, NOPW);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      step("R12 idle",          CL_ALU,  CL_ALU,  CL_ALU,  4'h1, 4'h2, 4'h3, 1'b1, 4'b0000);
      step("R1 load src_a",     CL_ALU,  CL_LOAD, CL_ALU,  4'h3, 4'h4, 4'h3, 1'b0, 4'b1101);
      step("R1 pop src_b",      CL_ALU,  CL_POP,  CL_NOP,  4'h1, 4'h5, 4'h5, 1'b0, 4'b1101);
      step("R1 load no match",  CL_ALU,  CL_LOAD, CL_NOP,  4'h4, 4'h6, 4'h3, 1'b0, 4'b0000);
      step("R1 alu same id",    CL_ALU,  CL_ALU,  CL_NOP,  4'h3, 4'h6, 4'h3, 1'b0, 4'b0000);
      step("R1 store same id",  CL_ALU,  CL_STORE,CL_NOP,  4'h3, 4'h6, 4'h3, 1'b0, 4'b0000);
      step("R2 ret in D",       CL_RET,  CL_ALU,  CL_NOP,  4'h1, 4'h2, 4'h3, 1'b0, 4'b1010);
      step("R2 ret in E",       CL_NOP,  CL_RET,  CL_NOP,  4'h1, 4'h2, 4'h3, 1'b0, 4'b1010);
      step("R2 ret in M",       CL_NOP,  CL_NOP,  CL_RET,  4'h1, 4'h2, 4'h3, 1'b0, 4'b1010);
      step("R3 jump not taken", CL_ALU,  CL_JUMP, CL_NOP,  4'h1, 4'h2, 4'h3, 1'b0, 4'b0011);
      step("R3 jump taken",     CL_ALU,  CL_JUMP, CL_NOP,  4'h1, 4'h2, 4'h3, 1'b1, 4'b0000);
      step("R4 mispredict+ret", CL_RET,  CL_JUMP, CL_NOP,  4'h1, 4'h2, 4'h3, 1'b0, 4'b1011);
      step("R5 loaduse+ret",    CL_RET,  CL_LOAD, CL_NOP,  4'h7, 4'hF, 4'h7, 1'b0, 4'b1101);
      step("R5 loaduse+retM",   CL_ALU,  CL_POP,  CL_RET,  4'hF, 4'h2, 4'h2, 1'b0, 4'b1101);
      step("R6 none ids",       CL_ALU,  CL_LOAD, CL_NOP,  4'hF, 4'hF, 4'hF, 1'b0, 4'b0000);
      step("R6 none ids ret",   CL_ALU,  CL_POP,  CL_RET,  4'h1, 4'hF, 4'hF, 1'b0, 4'b1010);
      step("R12 idle end",      CL_NOP,  CL_NOP,  CL_NOP,  4'h1, 4'h2, 4'h3, 1'b0, 4'b0000);
      step("R9 final",          CL_NOP,  CL_NOP,  CL_NOP,  4'h1, 4'h2, 4'h3, 1'b0, 4'b0000);

      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule